// File: doc/BRIEF.md
# Byte-Offset Packet Packer with End Tag

This block sits between a memory read path and a transmit FIFO that holds 36-bit tagged entries. A packet may start at any byte offset within a 32-bit memory word. The packer drops the leading bytes that lie before the packet, shifts the rest down and joins them with bytes from the next word. Each FIFO data entry therefore carries four consecutive packet bytes. Every packet ends with an end-of-packet entry, and that entry also clears the byte accumulator.

A packet begins with a one-cycle start pulse that gives the starting byte offset and the byte length. The block then accepts memory words while it signals ready. An underrun abort can stop the packet at any point. Even then the block writes the end entry, so no stale bytes remain in the accumulator. While idle, command entries from an upstream writer pass straight through to the FIFO, unchanged.

Top module: `pkt_aligner`

## Requirements
- R1: After reset, fifo_wr, busy and mem_ready are low and cmd_ready is high.
- R2: Entry layout: the tag is in bits 35:32 and data entries use tag 0x1. Packet byte i goes to data entry i/4, byte lane i%4, where lane k is bits 8k+7:8k. Memory byte lane k of the first word holds packet byte k-start_off. This holds for start offsets 0, 1, 2 and 3.
- R3: If the length is not a multiple of four, the final data entry has its unused upper byte lanes set to zero. It is written before the end entry.
- R4: A packet that completes is closed by exactly one entry with tag 0xE and bits 31:0 zero, written after its last data entry.
- R5: A start with length zero produces only the end entry.
- R6: An abort while mem_ready is high keeps the data entries already written and drops any held partial bytes. The end entry appears two clock edges after the abort edge.
- R7: After the end entry the block is idle with an empty accumulator. A command written next passes through unmerged.
- R8: While cmd_ready is high, a cmd_valid entry appears on the FIFO port one edge later with all 36 bits unchanged.
- R9: Memory words offered while mem_ready is low are ignored. Bytes in the last word beyond the packet length never reach the FIFO.
- R10: mem_ready and busy are high from the edge after an accepted start of non-zero length until the packet is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Packet start pulse, taken while idle |
| start_off | input | 2 | Byte offset of the first packet byte in the first word |
| start_len | input | LEN_W | Packet length in bytes |
| mem_valid | input | 1 | Memory word present |
| mem_data | input | 32 | Memory read word, byte lane k at bits 8k+7:8k |
| mem_ready | output | 1 | Block accepts memory words |
| abort | input | 1 | Underrun abort of the current packet |
| cmd_valid | input | 1 | Command entry present |
| cmd_entry | input | 36 | Command entry passed through |
| cmd_ready | output | 1 | Block accepts command entries |
| busy | output | 1 | A packet is in progress |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 36 | Tagged FIFO entry |

## Verification
The bench builds the block with its default parameters: a 12-bit length field, data tag 0x1 and end tag 0xE. Packet lengths from 0 to 40 bytes cover every combination of start offset and final-word fill. They also include packets that cross several words. Aborts are placed before the first word and after each later word. This reaches the empty, partly filled and overfull states of the accumulator. Random gaps between memory words check that the block does not depend on a steady stream.

// File: rtl/pkt_aligner.sv
module pkt_aligner #(
  parameter int LEN_W = 12,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] DATA_TAG = 4'h1,
  parameter logic [TAG_W-1:0] EOP_TAG = 4'hE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           start_off,
  input  logic [LEN_W-1:0]     start_len,
  input  logic                 mem_valid,
  input  logic [31:0]          mem_data,
  output logic                 mem_ready,
  input  logic                 abort,
  input  logic                 cmd_valid,
  input  logic [TAG_W+31:0]    cmd_entry,
  output logic                 cmd_ready,
  output logic                 busy,
  output logic                 fifo_wr,
  output logic [TAG_W+31:0]    fifo_data
);
  typedef enum logic [1:0] {S_IDLE, S_DATA, S_FLUSH, S_EOP} st_t;

  st_t              state;
  logic [55:0]      acc;
  logic [2:0]       cnt;
  logic [LEN_W-1:0] rem;
  logic             first;
  logic [1:0]       off;

  logic [1:0]       lo;
  logic [2:0]       avail, n, tot, cnt_nx;
  logic [31:0]      shifted, lane_mask;
  logic [55:0]      merged;
  logic [LEN_W-1:0] rem_nx;

  assign lo      = first ? off : 2'd0;
  assign avail   = 3'd4 - {1'b0, lo};
  assign n       = (rem < LEN_W'(avail)) ? rem[2:0] : avail;
  assign shifted = mem_data >> {lo, 3'b000};

  always_comb
    for (int k = 0; k < 4; k++)
      lane_mask[8*k +: 8] = (3'(k) < n) ? 8'hFF : 8'h00;

  assign merged = acc | ({24'd0, shifted & lane_mask} << {cnt, 3'b000});
  assign tot    = cnt + n;
  assign cnt_nx = (tot >= 3'd4) ? tot - 3'd4 : tot;
  assign rem_nx = rem - LEN_W'(n);

  assign mem_ready = (state == S_DATA);
  assign cmd_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      acc       <= '0;
      cnt       <= '0;
      rem       <= '0;
      first     <= 1'b1;
      off       <= '0;
      fifo_wr   <= 1'b0;
      fifo_data <= '0;
    end else begin
      fifo_wr <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            fifo_wr   <= 1'b1;
            fifo_data <= cmd_entry;
          end
          if (start) begin
            off   <= start_off;
            rem   <= start_len;
            first <= 1'b1;
            state <= (start_len == '0) ? S_EOP : S_DATA;
          end
        end
        S_DATA: begin
          if (abort) begin
            acc   <= '0;
            cnt   <= '0;
            state <= S_EOP;
          end else if (mem_valid) begin
            first <= 1'b0;
            rem   <= rem_nx;
            cnt   <= cnt_nx;
            if (tot >= 3'd4) begin
              fifo_wr   <= 1'b1;
              fifo_data <= {DATA_TAG, merged[31:0]};
              acc       <= merged >> 32;
            end else begin
              acc <= merged;
            end
            if (rem_nx == '0)
              state <= (cnt_nx != 3'd0) ? S_FLUSH : S_EOP;
          end
        end
        S_FLUSH: begin
          if (!abort) begin
            fifo_wr   <= 1'b1;
            fifo_data <= {DATA_TAG, acc[31:0]};
          end
          acc   <= '0;
          cnt   <= '0;
          state <= S_EOP;
        end
        default: begin
          fifo_wr   <= 1'b1;
          fifo_data <= {EOP_TAG, 32'd0};
          acc       <= '0;
          cnt       <= '0;
          first     <= 1'b1;
          state     <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pkt_aligner_chk.sv
module pkt_aligner_chk #(
  parameter int LEN_W = 12,
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] EOP_TAG = 4'hE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  start_len,
  input logic              abort,
  input logic              mem_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [TAG_W+31:0] cmd_entry,
  input logic              busy,
  input logic              fifo_wr,
  input logic [TAG_W+31:0] fifo_data,
  input logic [2:0]        acc_cnt
);
  p_abort_eop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready && abort |=> ##1 (fifo_wr && fifo_data[TAG_W+31:32] == EOP_TAG));

  p_empty_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start && cmd_ready && start_len == '0 |=> ##1 (fifo_wr && fifo_data[TAG_W+31:32] == EOP_TAG));

  p_cmd_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> fifo_wr && fifo_data == $past(cmd_entry));

  p_idle_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> acc_cnt == 3'd0);

  p_eop_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr && fifo_data[TAG_W+31:32] == EOP_TAG && $past(busy) |-> !busy && fifo_data[31:0] == 32'd0);
endmodule

bind pkt_aligner pkt_aligner_chk #(.LEN_W(LEN_W), .TAG_W(TAG_W), .EOP_TAG(EOP_TAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len), .abort(abort),
  .mem_ready(mem_ready), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_entry(cmd_entry), .busy(busy), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
  .acc_cnt(cnt)
);

// File: tb/pkt_aligner_tb.sv
module pkt_aligner_tb;
  localparam int LEN_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mem_valid = 1'b0, abort = 1'b0, cmd_valid = 1'b0;
  logic [1:0] start_off = '0;
  logic [LEN_W-1:0] start_len = '0;
  logic [31:0] mem_data = '0;
  logic [35:0] cmd_entry = '0;
  logic mem_ready, cmd_ready, busy, fifo_wr;
  logic [35:0] fifo_data;

  pkt_aligner #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off), .start_len(start_len),
    .mem_valid(mem_valid), .mem_data(mem_data), .mem_ready(mem_ready), .abort(abort),
    .cmd_valid(cmd_valid), .cmd_entry(cmd_entry), .cmd_ready(cmd_ready), .busy(busy),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_got = 0, n_exp = 0;
  bit done = 1'b0;
  logic [35:0] got [0:255];
  logic [35:0] expq [0:255];
  logic [7:0] pkt [0:63];

  always @(negedge clk)
    if (rst_n && fifo_wr && n_got < 256) begin
      got[n_got] = fifo_data;
      n_got++;
    end

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int expect_build(int off, int len, int abrt);
    int nb, nent;
    logic [31:0] w;
    nb = (abrt < 0) ? len : ((abrt == 0) ? 0 : (4*abrt - off < len ? 4*abrt - off : len));
    nent = (abrt < 0) ? (len + 3) / 4 : nb / 4;
    for (int e = 0; e < nent; e++) begin
      w = '0;
      for (int b = 0; b < 4; b++)
        if (4*e + b < nb) w[8*b +: 8] = pkt[4*e + b];
      expq[e] = {4'h1, w};
    end
    expq[nent] = {4'hE, 32'd0};
    return nent + 1;
  endfunction

  task automatic run_pkt(input int off, input int len, input int abrt);
    int nw, lim, idx;
    logic [31:0] w;
    string req;
    req = (abrt >= 0) ? "R6" : ((len == 0) ? "R5" : "R2");
    for (int i = 0; i < len; i++) pkt[i] = 8'($urandom);
    n_exp = expect_build(off, len, abrt);
    n_got = 0;
    start = 1'b1; start_off = 2'(off); start_len = LEN_W'(len);
    @(posedge clk); #1;
    start = 1'b0;
    if (len > 0) chk(mem_ready && busy, "R10", {34'd0, mem_ready, busy}, 36'd3);
    nw = (len == 0) ? 0 : (off + len + 3) / 4;
    lim = (abrt >= 0) ? abrt : nw;
    for (int k = 0; k < lim; k++) begin
      repeat ($urandom % 3) begin @(posedge clk); #1; end
      for (int l = 0; l < 4; l++) begin
        idx = 4*k + l - off;
        w[8*l +: 8] = (idx >= 0 && idx < len) ? pkt[idx] : 8'($urandom);
      end
      mem_valid = 1'b1; mem_data = w;
      @(posedge clk); #1;
      mem_valid = 1'b0;
    end
    if (abrt >= 0) begin
      abort = 1'b1;
      @(posedge clk); #1;
      abort = 1'b0;
    end
    repeat (3) begin @(posedge clk); #1; end
    while (busy) begin @(posedge clk); #1; end
    chk(n_got == n_exp, req, 36'(n_got), 36'(n_exp));
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      if (i == n_exp - 1)
        chk(got[i] === expq[i], "R4", got[i], expq[i]);
      else if (abrt < 0 && i == n_exp - 2 && (len % 4) != 0)
        chk(got[i] === expq[i], "R3", got[i], expq[i]);
      else
        chk(got[i] === expq[i], req, got[i], expq[i]);
    end
  endtask

  task automatic send_cmd(input logic [35:0] e, input string req);
    cmd_valid = 1'b1; cmd_entry = e;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(fifo_wr && fifo_data === e, req, fifo_data, e);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!fifo_wr && !busy && !mem_ready && cmd_ready, "R1",
        {32'd0, fifo_wr, busy, mem_ready, cmd_ready}, 36'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R9: words offered while idle are ignored
    n_got = 0;
    mem_valid = 1'b1; mem_data = 32'hDEADBEEF;
    repeat (3) begin @(posedge clk); #1; end
    mem_valid = 1'b0;
    chk(n_got == 0 && !busy, "R9", 36'(n_got), 36'd0);

    send_cmd(36'h03002910C, "R8");

    for (int o = 0; o < 4; o++) begin
      run_pkt(o, 0, -1);
      run_pkt(o, 1, -1);
      run_pkt(o, 3, -1);
      run_pkt(o, 4, -1);
      run_pkt(o, 5, -1);
      run_pkt(o, 9, -1);
      run_pkt(o, 13, 0);
      send_cmd(36'h0_3002910C, "R7");
      run_pkt(o, 13, 1);
      send_cmd(36'h0_A5A5_0F0F, "R7");
      run_pkt(o, 13, 2);
      send_cmd(36'hC_3002_910C, "R7");
      run_pkt(o, 13, 3);
    end

    for (int t = 0; t < 80; t++) begin
      int o, len, nw, ab;
      o = $urandom % 4;
      len = $urandom % 41;
      nw = (len == 0) ? 0 : (o + len + 3) / 4;
      ab = (nw > 0 && ($urandom % 3) == 0) ? int'($urandom % nw) : -1;
      run_pkt(o, len, ab);
      if ((t % 5) == 0) send_cmd({4'h0, 32'($urandom)}, "R7");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule